// File: doc/BRIEF.md
# Cycle Counter with Compare Timers

This block keeps a 32-bit count of core clock cycles and a configurable number of 32-bit compare registers. Each compare register has its own interrupt pending bit. The pending bit is set when the running count steps onto that register's value. Software uses one write port to load the count or any compare register. A select field chooses the target, a data word gives the value, and a strobe makes the write happen. The same register space can be read back combinationally through a read select.

A compare match is seen as an event: the count *arriving* at the compare value. It is not treated as a level condition. Three consequences follow:

- Loading a compare register with the value the count currently holds, or with the value the count reaches at that same edge, does not raise the interrupt until the count wraps all the way around.
- Loading the count re-arms every comparator against the new value, and the load itself never raises an interrupt.
- Writing a compare register clears its pending bit. A separate clear mask lets an interrupt handler acknowledge pending bits without moving the deadline.

Top module: `cycle_timer_top`

## Requirements
- R1: When the count is not being loaded, it advances by exactly one on every clock edge. It wraps from 0xFFFFFFFF to 0x00000000.
- R2: A write with select 0 loads the count with the write data. On the next read the count equals that data, because no increment is added on the load edge. The count then advances from there.
- R3: A write with select k, for 1 ≤ k ≤ NUM_CMP, loads compare register k-1 with the write data.
- R4: Pending bit i (irq_pend[i]) is set on an edge where the count increments into the value of compare register i. This includes an increment that wraps through zero.
- R5: Once set, a pending bit stays set until its compare register is written or its clear-mask bit is applied.
- R6: A write to compare register i clears pending bit i at that edge. The write wins over a match of the old compare value on the same edge.
- R7: A clear-mask bit held high across an edge clears that pending bit. A match on the same edge wins, and the bit ends up set.
- R8: Loading compare register i with the count visible on the read port in the write cycle does not set pending bit i in the following cycles. Loading it with that count plus one does not set it either.
- R9: A count load never sets a pending bit, even when the loaded value equals a compare value. Later matches are measured from the loaded count.
- R10: The read port is combinational. rd_sel 0 returns the count, rd_sel k (1..NUM_CMP) returns compare register k-1, and any other select returns zero.
- R11: A write whose select is above NUM_CMP changes neither the count sequence nor any compare register.
- R12: While rst_n is low at a clock edge, the count, every compare register and every pending bit are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the count advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register write port |
| wr_sel | input | SEL_W | Write target: 0 = count, k = compare register k-1 |
| wr_data | input | CNT_W | Value to write |
| rd_sel | input | SEL_W | Read target, same encoding as wr_sel |
| rd_data | output | CNT_W | Combinational read-back of the selected register |
| clr_mask | input | NUM_CMP | One bit per comparator; high clears that pending bit |
| irq_pend | output | NUM_CMP | Interrupt pending bits, one per comparator |

## Verification
The assertions run on every cycle and cover five behaviours: the count's step of one, the exact loaded value after a count write, the fact that every rising pending bit coincides with the count equal to its compare value, the stickiness of pending bits, and the rule that count loads and out-of-range writes leave the comparators untouched. Other behaviours need a history of stimulus, so only the bench scenarios can show them. These are the edge-ordering corner cases: a compare write landing on the very edge of the old match, a clear colliding with a match, a compare set equal to the live count, and a match reached only by wrapping through zero.

// File: rtl/timer_pkg.sv
// Package: shared widths and types for the cycle counter and compare timers.
// Assumes: the counter width is fixed by the architecture at 32 bits.
package timer_pkg;
    localparam int CNT_W_DEF = 32;
    localparam int NUM_CMP_DEF = 3;
    localparam int SEL_W_DEF = 3;

    typedef logic [CNT_W_DEF-1:0] cnt_t;
endpackage

// File: rtl/tmr_wr_decode.sv
// Module: tmr_wr_decode
// Turns the write strobe and select into one count-load enable and one
// write enable per compare register. Assumes SEL_W can encode NUM_CMP;
// select values above NUM_CMP decode to nothing.
module tmr_wr_decode #(
    parameter int NUM_CMP = timer_pkg::NUM_CMP_DEF,
    parameter int SEL_W   = timer_pkg::SEL_W_DEF
) (
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    output logic               load_cnt,
    output logic [NUM_CMP-1:0] cmp_wr
);
    // Select 0 addresses the running count.
    always_comb begin
        load_cnt = wr_en && (wr_sel == '0);
    end

    // One enable per comparator, select k mapping to comparator k-1.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_dec
        assign cmp_wr[g] = wr_en && (wr_sel == SEL_W'(g + 1));
    end
endmodule

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// Free-running cycle count. A load replaces the increment on that edge.
// Exposes the next-state value and whether the coming edge increments,
// so comparators can detect the count stepping onto their value.
module tmr_counter #(
    parameter int CNT_W = timer_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_nxt,
    output logic             incr
);
    // Next count: loaded value, or current value plus one (modular).
    always_comb begin
        incr      = !load_en;
        count_nxt = load_en ? load_val : count_q + CNT_W'(1);
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_nxt;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// Module: tmr_channel
// One comparator: a compare register plus its pending bit. A match is the
// count incrementing onto the compare value; loads of the count never
// match. Priority on an edge: compare write (clears) > match (sets) > clear.
module tmr_channel #(
    parameter int CNT_W = timer_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic             incr,
    input  logic             clr,
    output logic [CNT_W-1:0] cmp_q,
    output logic             pend_q
);
    logic hit;

    // Match event: an increment whose result equals the held compare value.
    always_comb begin
        hit = incr && (count_nxt == cmp_q);
    end

    // Compare register, loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= wr_data;
        end
    end

    // Pending bit with write-clear, match-set and acknowledge-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (cmp_wr) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (clr) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_readmux.sv
// Module: tmr_readmux
// Combinational read-back: select 0 gives the count, select k gives
// comparator k-1, and unmapped selects give zero. No latency stage.
module tmr_readmux #(
    parameter int CNT_W   = timer_pkg::CNT_W_DEF,
    parameter int NUM_CMP = timer_pkg::NUM_CMP_DEF,
    parameter int SEL_W   = timer_pkg::SEL_W_DEF
) (
    input  logic [SEL_W-1:0]              rd_sel,
    input  logic [CNT_W-1:0]              count_q,
    input  logic [NUM_CMP-1:0][CNT_W-1:0] cmp_all,
    output logic [CNT_W-1:0]              rd_data
);
    // Select the addressed register, defaulting to zero.
    always_comb begin
        rd_data = '0;
        if (rd_sel == '0) begin
            rd_data = count_q;
        end
        for (int k = 0; k < NUM_CMP; k++) begin
            if (rd_sel == SEL_W'(k + 1)) begin
                rd_data = cmp_all[k];
            end
        end
    end
endmodule

// File: rtl/cycle_timer_top.sv
// Module: cycle_timer_top
// Cycle counter with NUM_CMP compare timers and per-comparator pending
// bits. Assumes a single write per cycle, a synchronous active-low reset,
// and SEL_W wide enough to encode NUM_CMP.
module cycle_timer_top #(
    parameter int CNT_W   = timer_pkg::CNT_W_DEF,
    parameter int NUM_CMP = timer_pkg::NUM_CMP_DEF,
    parameter int SEL_W   = timer_pkg::SEL_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [CNT_W-1:0]   rd_data,
    input  logic [NUM_CMP-1:0] clr_mask,
    output logic [NUM_CMP-1:0] irq_pend
);
    logic                       load_cnt;
    logic [NUM_CMP-1:0]         cmp_wr;
    logic [CNT_W-1:0]           count_q;
    logic [CNT_W-1:0]           count_nxt;
    logic                       incr;
    logic [NUM_CMP-1:0][CNT_W-1:0] cmp_all;

    tmr_wr_decode #(.NUM_CMP(NUM_CMP), .SEL_W(SEL_W)) u_dec (
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .load_cnt (load_cnt),
        .cmp_wr   (cmp_wr)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_cnt),
        .load_val  (wr_data),
        .count_q   (count_q),
        .count_nxt (count_nxt),
        .incr      (incr)
    );

    // One comparator channel per compare register.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_wr    (cmp_wr[g]),
            .wr_data   (wr_data),
            .count_nxt (count_nxt),
            .incr      (incr),
            .clr       (clr_mask[g]),
            .cmp_q     (cmp_all[g]),
            .pend_q    (irq_pend[g])
        );
    end

    tmr_readmux #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .SEL_W(SEL_W)) u_rd (
        .rd_sel  (rd_sel),
        .count_q (count_q),
        .cmp_all (cmp_all),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/cycle_timer_chk.sv
// Module: cycle_timer_chk
// Assertion checker bound to cycle_timer_top. Observes the write port,
// the clear mask, the count, the compare registers and the pending bits.
module cycle_timer_chk #(
    parameter int CNT_W   = timer_pkg::CNT_W_DEF,
    parameter int NUM_CMP = timer_pkg::NUM_CMP_DEF,
    parameter int SEL_W   = timer_pkg::SEL_W_DEF
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [SEL_W-1:0]              wr_sel,
    input logic [CNT_W-1:0]              wr_data,
    input logic [NUM_CMP-1:0]            clr_mask,
    input logic [CNT_W-1:0]              count,
    input logic [NUM_CMP-1:0][CNT_W-1:0] cmp_all,
    input logic [NUM_CMP-1:0]            pend
);
    // R12: a reset edge leaves the count and all pending bits at zero.
    a_r12_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && pend == '0));

    // R1: without a load, the count steps by one.
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == '0) |=> count == $past(count) + CNT_W'(1));

    // R2: a load leaves exactly the written value, with no increment.
    a_r2_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> count == $past(wr_data));

    // R11: writes beyond the last comparator leave every compare register alone.
    a_r11_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > SEL_W'(NUM_CMP)) |=> cmp_all == $past(cmp_all));

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_chk
        // R4: a pending bit rises only with the count on its compare value.
        a_r4_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[g]) |-> count == cmp_all[g]);

        // R3 and R6: a compare write loads the value and clears the bit.
        a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == SEL_W'(g + 1)) |=> (!pend[g] && cmp_all[g] == $past(wr_data)));

        // R5: a pending bit holds unless written or acknowledged.
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[g] && !clr_mask[g] && !(wr_en && wr_sel == SEL_W'(g + 1))) |=> pend[g]);

        // R9: a count load never raises a pending bit.
        a_r9_load_no_set: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == '0 && !pend[g]) |=> !pend[g]);
    end
endmodule

bind cycle_timer_top cycle_timer_chk #(
    .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .SEL_W(SEL_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .clr_mask (clr_mask),
    .count    (count_q),
    .cmp_all  (cmp_all),
    .pend     (irq_pend)
);

// File: tb/cycle_timer_top_tb_top.sv
`timescale 1ns/1ps
// Bench for cycle_timer_top: a vector table of writes with read-back,
// then directed scenarios for matches, clears, wrap and reset.
module cycle_timer_top_tb_top;
    localparam int W  = 32;
    localparam int N  = 3;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_sel = '0;
    logic [W-1:0]  wr_data = '0;
    logic [SW-1:0] rd_sel = '0;
    logic [N-1:0]  clr_mask = '0;
    logic [W-1:0]  rd_data;
    logic [N-1:0]  irq_pend;

    int n_chk = 0;
    int n_err = 0;

    // Vector table: {select, data}; each row is written and read back.
    localparam logic [SW+W-1:0] VEC [7] = '{
        {3'd1, 32'h1111_1111},
        {3'd2, 32'h2222_2222},
        {3'd3, 32'h3333_3333},
        {3'd0, 32'h0000_0040},
        {3'd3, 32'hFFFF_FFFF},
        {3'd2, 32'h8000_0000},
        {3'd1, 32'hA5A5_A5A5}
    };

    cycle_timer_top #(.CNT_W(W), .NUM_CMP(N), .SEL_W(SW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .clr_mask (clr_mask),
        .irq_pend (irq_pend)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic wr(input logic [SW-1:0] s, input logic [W-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [SW-1:0] s, output logic [W-1:0] v);
        rd_sel = s;
        #0.2;
        v = rd_data;
    endtask

    task automatic clr(input logic [N-1:0] m);
        clr_mask = m;
        @(negedge clk);
        clr_mask = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] v, a, c, d;
        // R12: state under reset.
        step(3);
        rd(3'd0, v); chk("R12 count in reset", v, '0);
        for (int k = 1; k <= N; k++) begin
            rd(SW'(k), v); chk("R12 compare in reset", v, '0);
        end
        chk("R12 pending in reset", W'(irq_pend), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R10: table of writes with immediate read-back.
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][SW+W-1:W], VEC[i][W-1:0]);
            rd(VEC[i][SW+W-1:W], v);
            chk("R2/R3/R10 table readback", v, VEC[i][W-1:0]);
        end

        // R1: steady increment.
        rd(3'd0, a); step(3); rd(3'd0, v);
        chk("R1 count advances one per cycle", v, a + 32'd3);

        // R10: unmapped read select returns zero.
        rd(3'd6, v); chk("R10 unmapped read", v, '0);

        // R2: no increment on the load edge, then resumes.
        wr(3'd0, 32'd1000); rd(3'd0, v); chk("R2 load value exact", v, 32'd1000);
        step(1); rd(3'd0, v); chk("R2 resumes counting", v, 32'd1001);

        // R4 R5: match sets and holds.
        wr(3'd0, 32'd100);
        wr(3'd1, 32'd110);
        step(8); chk("R4 not yet matched at 109", W'(irq_pend), '0);
        step(1); rd(3'd0, v); chk("R4 count at match", v, 32'd110);
        chk("R4 pending set on match", W'(irq_pend), 32'b001);
        step(5); chk("R5 pending sticky", W'(irq_pend), 32'b001);

        // R7: acknowledge clears.
        clr(3'b001); chk("R7 clear mask clears", W'(irq_pend), '0);

        // R6: compare write clears a set bit.
        wr(3'd0, 32'd150); wr(3'd1, 32'd152); step(1);
        chk("R4 second match", W'(irq_pend), 32'b001);
        wr(3'd1, 32'd400); chk("R6 compare write clears", W'(irq_pend), '0);

        // R6: compare write wins over a match on the same edge.
        wr(3'd0, 32'd300); step(99);
        wr(3'd1, 32'd1000); rd(3'd0, v); chk("R6 count reached old compare", v, 32'd400);
        chk("R6 write beats match", W'(irq_pend), '0);

        // R7: match wins over a clear on the same edge.
        step(599); rd(3'd0, v); chk("R7 count before match", v, 32'd999);
        clr(3'b001); chk("R7 match beats clear", W'(irq_pend), 32'b001);
        clr(3'b001);

        // R8: compare equal to live count, or to count plus one, stays silent.
        rd(3'd0, c); wr(3'd2, c);
        rd(3'd0, d); wr(3'd3, d + 32'd1);
        step(40); chk("R8 equal compare does not fire", W'(irq_pend), '0);

        // R9: loading the count onto a compare value does not fire; re-arm works.
        wr(3'd0, d + 32'd1); chk("R9 load onto compare silent", W'(irq_pend), '0);
        step(5); chk("R9 still silent after load", W'(irq_pend), '0);
        wr(3'd3, 32'd6000); wr(3'd0, 32'd5990); step(9);
        chk("R9 not before re-armed match", W'(irq_pend), '0);
        step(1); chk("R9 re-armed match fires alone", W'(irq_pend), 32'b100);
        clr(3'b100);

        // R1 R4: wrap through zero, match after wrap.
        wr(3'd2, 32'd2); wr(3'd0, 32'hFFFF_FFFC);
        step(4); rd(3'd0, v); chk("R1 wraps to zero", v, '0);
        chk("R4 no match before wrap target", W'(irq_pend), '0);
        step(2); chk("R4 match across wrap", W'(irq_pend), 32'b010);

        // R11: out-of-range write ignored.
        rd(3'd0, a); wr(3'd5, 32'hDEAD_BEEF); rd(3'd0, v);
        chk("R11 count unaffected", v, a + 32'd1);
        rd(3'd1, v); chk("R11 compare0 unchanged", v, 32'd1000);
        rd(3'd2, v); chk("R11 compare1 unchanged", v, 32'd2);
        rd(3'd3, v); chk("R11 compare2 unchanged", v, 32'd6000);

        // R12: reset mid-run.
        rst_n = 1'b0; step(1);
        rd(3'd0, v); chk("R12 count after reset", v, '0);
        rd(3'd3, v); chk("R12 compare after reset", v, '0);
        chk("R12 pending after reset", W'(irq_pend), '0);
        rst_n = 1'b1;

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule